// File: doc/BRIEF.md
# Memory Refresh Scheduler and Port Arbiter

This block sits in front of a DDR command unit. It decides which of three requesters may use the memory interface next: the north bus port, the south bus port, or the refresh logic. A free-running interval timer marks when a refresh falls due. Each time it expires, one refresh is added to a count of owed refreshes. The arbiter pays these back with one refresh strobe per refresh.

A refresh never cuts into work already granted. A south transaction runs until it completes. A north tenure runs until it has completed its programmed number of transactions or the port drops its request. Refreshes that come due in the meantime are remembered, up to a saturating limit. Once the interface is idle they are issued one after another, and no port is granted between them. Each refresh holds the interface until the command unit reports that it has finished.

The controller is built around five named states:
- `ST_IDLE`: nothing granted.
- `ST_NORTH`: north tenure.
- `ST_SOUTH`: a single south transaction.
- `ST_REF_ISSUE`: the one-cycle refresh strobe.
- `ST_REF_WAIT`: waiting for the refresh to finish.

Transitions:
- `ST_IDLE` to `ST_REF_ISSUE`: refreshes are owed.
- `ST_IDLE` to `ST_NORTH` or `ST_SOUTH`: round-robin choice among the requesting ports.
- `ST_NORTH` to `ST_IDLE`: the tenure count is reached or the request is dropped.
- `ST_SOUTH` to `ST_IDLE`: south done.
- `ST_REF_ISSUE` to `ST_REF_WAIT`: always, after one cycle.
- `ST_REF_WAIT` to `ST_IDLE`: refresh done.

Top module: `mem_refresh_sched`

## Requirements
- R1: After reset no grant and no refresh strobe is asserted, and the owed-refresh count is zero.
- R2: With a nonzero interval N, the 12-bit timer expires once every N cycles. It restarts from zero on every expiry, whether or not the refresh has been issued yet.
- R3: Each expiry adds one owed refresh and each refresh strobe removes one. An expiry and a strobe in the same cycle leave the count unchanged. Every owed refresh is eventually issued.
- R4: The owed-refresh count saturates at 15. Further expiries are lost.
- R5: A refresh that falls due never interrupts a granted south transaction or a north tenure. No strobe is issued while either grant is high, nor in the cycle after either grant is high.
- R6: From idle with refreshes owed, refresh wins over both ports. All owed refreshes are issued before the next port grant.
- R7: When both ports request at idle, the port not served last is granted. After reset the north port is first.
- R8: A north grant lasts until the programmed burst count of north completions has been seen (a count of 0 acts as 1), or until north_req is low. It then drops in the next cycle.
- R9: A south grant covers one transaction and drops in the cycle after south_done.
- R10: An interval of zero stops the timer and clears all owed refreshes. No strobe follows from refreshes that were owed before.
- R11: The refresh strobe is one cycle wide. From the strobe until ref_done, no grant is given. At most one of north grant, south grant and strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ref_interval | input | CNT_W (12) | Refresh period in cycles; 0 disables refresh |
| cfg_north_burst | input | BURST_W (4) | North completions per tenure; 0 acts as 1 |
| north_req | input | 1 | North port has transactions to run |
| north_done | input | 1 | One north transaction completed |
| south_req | input | 1 | South port has a transaction to run |
| south_done | input | 1 | The south transaction completed |
| ref_done | input | 1 | Command unit finished the current refresh |
| north_gnt | output | 1 | North port owns the interface |
| south_gnt | output | 1 | South port owns the interface |
| ref_strobe | output | 1 | One-cycle refresh command |

## Verification
The bench builds the block with its default parameters: a 12-bit timer, a 4-bit owed count and a 4-bit north burst field. With the 4-bit owed count, saturation at 15 is reached by holding a north tenure across 17 expiries at an interval of 8. The 12-bit interval also allows a value of 4000, which the bench writes on releasing the interface so that no new expiry lands while the backlog is counted. A burst value of 3 lets tenure ends, round-robin hand-over and south single-transaction grants be seen within a few cycles.

// File: rtl/rsched_pkg.sv
package rsched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_NORTH     = 3'd1,
        ST_SOUTH     = 3'd2,
        ST_REF_ISSUE = 3'd3,
        ST_REF_WAIT  = 3'd4
    } arb_state_t;

endpackage

// File: rtl/rsched_interval_timer.sv
module rsched_interval_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval,
    output logic             expire
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             enabled;

    assign enabled = (interval != '0);
    // ">=" so that lowering the interval below the running count still expires
    assign expire  = enabled && (cnt_q >= (interval - STEP));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enabled || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + STEP;
        end
    end

endmodule

// File: rtl/rsched_owed_counter.sv
module rsched_owed_counter #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              expire,
    input  logic              issue,
    output logic [PEND_W-1:0] pend,
    output logic              owed
);

    localparam logic [PEND_W-1:0] MAXV = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] STEP = PEND_W'(1);

    logic [PEND_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (!enable) begin
            pend_q <= '0;
        end else begin
            case ({expire, issue})
                2'b10: if (pend_q != MAXV) pend_q <= pend_q + STEP;
                2'b01: if (pend_q != '0)   pend_q <= pend_q - STEP;
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign pend = pend_q;
    assign owed = (pend_q != '0);

endmodule

// File: rtl/rsched_arb_fsm.sv
module rsched_arb_fsm
    import rsched_pkg::*;
#(
    parameter int BURST_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               owed,
    input  logic [BURST_W-1:0] cfg_burst,
    input  logic               north_req,
    input  logic               north_done,
    input  logic               south_req,
    input  logic               south_done,
    input  logic               ref_done,
    output logic               north_gnt,
    output logic               south_gnt,
    output logic               ref_strobe
);

    localparam int                 EXT_W = BURST_W + 1;
    localparam logic [EXT_W-1:0]   ONE_E = EXT_W'(1);
    localparam logic [BURST_W-1:0] ONE_B = BURST_W'(1);

    arb_state_t         state_q, state_d;
    logic [BURST_W-1:0] tcnt_q;
    logic               last_north_q;
    logic [EXT_W-1:0]   limit_ext;
    logic               burst_last;

    assign limit_ext  = (cfg_burst == '0) ? ONE_E : {1'b0, cfg_burst};
    assign burst_last = north_done && (({1'b0, tcnt_q} + ONE_E) >= limit_ext);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (owed) begin
                    state_d = ST_REF_ISSUE;
                end else if (north_req && (!last_north_q || !south_req)) begin
                    state_d = ST_NORTH;
                end else if (south_req) begin
                    state_d = ST_SOUTH;
                end
            end
            ST_NORTH: begin
                if (!north_req || burst_last) state_d = ST_IDLE;
            end
            ST_SOUTH: begin
                if (south_done) state_d = ST_IDLE;
            end
            ST_REF_ISSUE: state_d = ST_REF_WAIT;
            ST_REF_WAIT: begin
                if (ref_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Tenure completion count and round-robin memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q       <= '0;
            last_north_q <= 1'b0;
        end else begin
            if (state_q != ST_NORTH)  tcnt_q <= '0;
            else if (north_done)      tcnt_q <= tcnt_q + ONE_B;
            if (state_q == ST_IDLE && state_d == ST_NORTH) last_north_q <= 1'b1;
            if (state_q == ST_IDLE && state_d == ST_SOUTH) last_north_q <= 1'b0;
        end
    end

    // Outputs decoded from state
    always_comb begin
        north_gnt  = 1'b0;
        south_gnt  = 1'b0;
        ref_strobe = 1'b0;
        unique case (state_q)
            ST_NORTH:     north_gnt  = 1'b1;
            ST_SOUTH:     south_gnt  = 1'b1;
            ST_REF_ISSUE: ref_strobe = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mem_refresh_sched.sv
module mem_refresh_sched #(
    parameter int CNT_W   = 12,
    parameter int PEND_W  = 4,
    parameter int BURST_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cfg_ref_interval,
    input  logic [BURST_W-1:0] cfg_north_burst,
    input  logic               north_req,
    input  logic               north_done,
    input  logic               south_req,
    input  logic               south_done,
    input  logic               ref_done,
    output logic               north_gnt,
    output logic               south_gnt,
    output logic               ref_strobe
);

    logic              ref_due;
    logic              ref_owed;
    logic              ref_enable;
    logic [PEND_W-1:0] pend_cnt;

    assign ref_enable = (cfg_ref_interval != '0);

    rsched_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (cfg_ref_interval),
        .expire   (ref_due)
    );

    rsched_owed_counter #(.PEND_W(PEND_W)) u_owed (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ref_enable),
        .expire (ref_due),
        .issue  (ref_strobe),
        .pend   (pend_cnt),
        .owed   (ref_owed)
    );

    rsched_arb_fsm #(.BURST_W(BURST_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .owed       (ref_owed),
        .cfg_burst  (cfg_north_burst),
        .north_req  (north_req),
        .north_done (north_done),
        .south_req  (south_req),
        .south_done (south_done),
        .ref_done   (ref_done),
        .north_gnt  (north_gnt),
        .south_gnt  (south_gnt),
        .ref_strobe (ref_strobe)
    );

endmodule

// File: rtl/rsched_checker.sv
module rsched_checker #(
    parameter int CNT_W  = 12,
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cfg_ref_interval,
    input logic              north_req,
    input logic              south_done,
    input logic              north_gnt,
    input logic              south_gnt,
    input logic              ref_strobe,
    input logic              expire,
    input logic [PEND_W-1:0] pend
);

    localparam logic [PEND_W-1:0] MAXV = {PEND_W{1'b1}};

    assert_one_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({north_gnt, south_gnt, ref_strobe}));

    assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |=> !ref_strobe);

    assert_no_grant_after_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |=> (!north_gnt && !south_gnt));

    assert_no_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (north_gnt || south_gnt) |=> !ref_strobe);

    assert_north_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (north_gnt && !north_req) |=> !north_gnt);

    assert_south_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (south_gnt && south_done) |=> !south_gnt);

    assert_zero_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ref_interval == '0) |=> (pend == '0));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == MAXV && !ref_strobe && cfg_ref_interval != '0) |=> (pend == MAXV));

    assert_issue_decrements_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_strobe && !expire && cfg_ref_interval != '0) |=> (pend == $past(pend) - 1'b1));

    assert_both_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_strobe && expire && cfg_ref_interval != '0) |=> $stable(pend));

endmodule

bind mem_refresh_sched rsched_checker #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_ref_interval (cfg_ref_interval),
    .north_req        (north_req),
    .south_done       (south_done),
    .north_gnt        (north_gnt),
    .south_gnt        (south_gnt),
    .ref_strobe       (ref_strobe),
    .expire           (ref_due),
    .pend             (pend_cnt)
);

// File: tb/mem_refresh_sched_tb.sv
`timescale 1ns/1ps
module mem_refresh_sched_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_ref_interval = '0;
    logic [3:0]  cfg_north_burst = '0;
    logic        north_req = 1'b0, north_done = 1'b0;
    logic        south_req = 1'b0, south_done = 1'b0;
    logic        ref_done = 1'b0;
    logic        north_gnt, south_gnt, ref_strobe;

    int checks = 0, fails = 0;
    int pulses = 0, pulses_at_ngnt = 0, viol = 0;
    bit seen_ngnt = 0, done_pending = 0, finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    mem_refresh_sched u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_ref_interval (cfg_ref_interval), .cfg_north_burst (cfg_north_burst),
        .north_req (north_req), .north_done (north_done),
        .south_req (south_req), .south_done (south_done),
        .ref_done (ref_done),
        .north_gnt (north_gnt), .south_gnt (south_gnt), .ref_strobe (ref_strobe)
    );

    // Monitor and refresh responder: samples at the falling edge, answers one cycle after a strobe
    always @(negedge clk) begin
        if (!rst_n) begin
            ref_done     = 1'b0;
            done_pending = 1'b0;
        end else begin
            if ((ref_strobe || ref_done) && (north_gnt || south_gnt)) viol++;
            if (north_gnt && south_gnt) viol++;
            if (ref_strobe) pulses++;
            if (north_gnt && !seen_ngnt) begin
                seen_ngnt      = 1'b1;
                pulses_at_ngnt = pulses;
            end
            if (ref_strobe) begin
                done_pending = 1'b1;
                ref_done     = 1'b0;
            end else if (done_pending) begin
                ref_done     = 1'b1;
                done_pending = 1'b0;
            end else begin
                ref_done = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int interval, input int burst);
        @(negedge clk);
        rst_n = 1'b0;
        north_req = 0; north_done = 0; south_req = 0; south_done = 0;
        cfg_ref_interval = 12'(interval);
        cfg_north_burst  = 4'(burst);
        repeat (3) @(negedge clk);
        pulses = 0; seen_ngnt = 0; pulses_at_ngnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic pulse_ndone();
        north_done = 1'b1;
        @(negedge clk);
        north_done = 1'b0;
    endtask

    // {interval, cycles the north tenure is held, refreshes owed afterwards}
    localparam int NROWS = 5;
    localparam int TBL [NROWS][3] = '{
        '{20,  70,  3},
        '{ 8, 140, 15},
        '{12,  30,  2},
        '{50,  40,  0},
        '{ 6,  15,  2}
    };

    initial begin
        // R1: reset state
        do_reset(0, 3);
        check(!north_gnt, "R1", north_gnt, 0);
        check(!south_gnt, "R1", south_gnt, 0);
        check(!ref_strobe, "R1", ref_strobe, 0);

        // R2 R3 R4 R5: backlog built behind a north tenure, then paid back
        for (int i = 0; i < NROWS; i++) begin
            do_reset(TBL[i][0], 15);
            north_req = 1'b1;
            repeat (TBL[i][1]) @(negedge clk);
            check(pulses == 0, "R5", pulses, 0);
            north_req = 1'b0;
            cfg_ref_interval = 12'd4000;
            repeat (60) @(negedge clk);
            check(pulses == TBL[i][2], (TBL[i][2] == 15) ? "R4" : "R2_R3", pulses, TBL[i][2]);
        end

        // R7 R8 R9: tenure count, round-robin, single south transaction
        do_reset(0, 3);
        north_req = 1'b1; south_req = 1'b1;
        @(negedge clk);
        check(north_gnt, "R7", north_gnt, 1);
        pulse_ndone();
        pulse_ndone();
        check(north_gnt, "R8", north_gnt, 1);
        pulse_ndone();
        check(!north_gnt, "R8", north_gnt, 0);
        @(negedge clk);
        check(south_gnt, "R7", south_gnt, 1);
        south_done = 1'b1;
        @(negedge clk);
        south_done = 1'b0;
        check(!south_gnt, "R9", south_gnt, 0);
        @(negedge clk);
        check(north_gnt, "R7", north_gnt, 1);
        north_req = 1'b0;
        @(negedge clk);
        check(!north_gnt, "R8", north_gnt, 0);

        // R5 R6: refreshes wait for the south transaction, then win over north
        do_reset(10, 15);
        south_req = 1'b1;
        repeat (25) @(negedge clk);
        check(pulses == 0, "R5", pulses, 0);
        cfg_ref_interval = 12'd4000;
        north_req = 1'b1; south_done = 1'b1;
        @(negedge clk);
        south_done = 1'b0; south_req = 1'b0;
        repeat (20) @(negedge clk);
        check(pulses == 2, "R6", pulses, 2);
        check(seen_ngnt, "R6", seen_ngnt, 1);
        check(pulses_at_ngnt == 2, "R6", pulses_at_ngnt, 2);
        north_req = 1'b0;

        // R10: zero interval discards owed refreshes
        do_reset(5, 15);
        north_req = 1'b1;
        repeat (22) @(negedge clk);
        cfg_ref_interval = 12'd0;
        repeat (2) @(negedge clk);
        cfg_ref_interval = 12'd4000;
        north_req = 1'b0;
        repeat (20) @(negedge clk);
        check(pulses == 0, "R10", pulses, 0);

        // R11: no grant while a refresh is outstanding, grants exclusive
        check(viol == 0, "R11", viol, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule